// File: doc/BRIEF.md
# Five-Bit-Coded Combined ALU

This block is the combinational arithmetic-logic unit of a single-cycle processor datapath. It takes two operands and a 5-bit operation code and returns one result word together with a flag that is high when that word is all zeros. Its callers are the register-to-register, immediate, load/store address, branch-compare and set-on-less-than instructions. Each of them selects one of the block's behaviours through the operation code.

Four units run in parallel: an adder/subtractor, a two-input boolean unit, a bidirectional barrel shifter, and a less-than comparator. The comparator takes the negative, overflow and carry flags of a forced subtraction. A result selector picks one unit's output. The operation code is split into fields: a subtract bit, a 2-bit selector, a shift-path bit and an arithmetic-path bit. The shifter shifts operand B by an amount taken from the low bits of operand A. The operand width is a parameter, and the shift amount uses log2(WIDTH) bits.

Top module: `combo_alu`

## Requirements
- R1: The operation code packs fields as fn[4] = subtract, fn[3:2] = selector, fn[1] = shift path, fn[0] = arithmetic path. When fn[0] and fn[1] are both 1, the arithmetic path wins.
- R2: With fn[0]=1, fn[2]=0 and fn[4]=0, the result is A+B modulo 2^WIDTH.
- R3: With fn[0]=1, fn[2]=0 and fn[4]=1, the result is A-B modulo 2^WIDTH.
- R4: With fn[0]=1 and fn[3:2]=01, the result is 1 when A is less than B as two's-complement numbers and 0 otherwise, in bit 0, with all other bits zero. The value of fn[4] does not change it.
- R5: With fn[0]=1 and fn[3:2]=11, the result is 1 when A is less than B as unsigned numbers and 0 otherwise, in bit 0, with all other bits zero. The value of fn[4] does not change it.
- R6: With fn[0]=0, fn[1]=1 and fn[3]=0, the result is B shifted left logically by A[log2(WIDTH)-1:0]. Higher bits of A have no effect.
- R7: With fn[0]=0, fn[1]=1 and fn[3]=1, the result is B shifted right by A[log2(WIDTH)-1:0]. The shift is logical when fn[2]=0 and fills with B's top bit when fn[2]=1.
- R8: With fn[0]=0 and fn[1]=0, the result is a bitwise function of A and B chosen by fn[3:2]: 00 AND, 01 OR, 10 XOR, 11 NOR.
- R9: The zero output is 1 exactly when every result bit is 0.
- R10: Outside the arithmetic path (fn[0]=0), fn[4] has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Operand A; also the shift amount source |
| b | input | WIDTH | Operand B; the value that is shifted |
| fn | input | 5 | Operation code {subtract, selector[1:0], shift path, arithmetic path} |
| result | output | WIDTH | Selected unit output |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds one copy at WIDTH=8, where the 3-bit shift amount and 8-bit operands are small. It sweeps all 32 operation codes, every value of A, and a spread of 32 values of B. That covers every field combination, including the undefined ones where the arithmetic path has priority. It also covers the signed and unsigned comparison boundaries, every shift distance, and A values with unused high bits set. A second copy at WIDTH=32 takes directed cases: sum wraparound, extreme signed comparisons, a full-width arithmetic shift, and a shift amount above 31 whose upper bits are dropped.

// File: rtl/combo_alu_pkg.sv
// Package: shared operation-code layout and path decode for the combined ALU.
// Assumes the 5-bit code layout {sub, sel[1:0], shift, math}.
package combo_alu_pkg;

    typedef struct packed {
        logic       sub;
        logic [1:0] sel;
        logic       shift;
        logic       math;
    } fn_t;

    typedef enum logic [1:0] {
        PATH_BOOL  = 2'd0,
        PATH_SHIFT = 2'd1,
        PATH_MATH  = 2'd2
    } path_e;

    // Arithmetic path has priority over the shifter; otherwise boolean.
    function automatic path_e pick_path(fn_t f);
        if (f.math)       return PATH_MATH;
        else if (f.shift) return PATH_SHIFT;
        else              return PATH_BOOL;
    endfunction

endpackage

// File: rtl/combo_alu_arith.sv
// Module: adder/subtractor with less-than compare derived from its flags.
// Compare mode forces subtraction; signed less-than is N^V, unsigned is ~C.
// Assumes WIDTH >= 2.
module combo_alu_arith #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub_req,
    input  logic             cmp_en,
    input  logic             cmp_unsigned,
    output logic [WIDTH-1:0] res
);
    logic             sub_eff;
    logic [WIDTH-1:0] b_op;
    logic [WIDTH-1:0] sum;
    logic             carry;
    logic             flag_n;
    logic             flag_v;
    logic             lt_bit;

    // Form the adder operand and the carry-in for add or subtract.
    always_comb begin
        sub_eff = sub_req | cmp_en;
        b_op    = sub_eff ? ~b : b;
    end

    // Ripple-free behavioural add producing carry out.
    always_comb begin
        {carry, sum} = {1'b0, a} + {1'b0, b_op} + {{WIDTH{1'b0}}, sub_eff};
    end

    // Derive negative and overflow flags and pick the comparison outcome.
    always_comb begin
        flag_n = sum[WIDTH-1];
        flag_v = (a[WIDTH-1] == b_op[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
        lt_bit = cmp_unsigned ? ~carry : (flag_n ^ flag_v);
    end

    // Present either the sum or the zero-extended comparison bit.
    always_comb begin
        if (cmp_en) res = {{(WIDTH-1){1'b0}}, lt_bit};
        else        res = sum;
    end
endmodule

// File: rtl/combo_alu_bool.sv
// Module: two-input bitwise unit; selector picks AND, OR, XOR or NOR.
module combo_alu_bool #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] res
);
    // Choose the bitwise function.
    always_comb begin
        case (sel)
            2'b00:   res = a & b;
            2'b01:   res = a | b;
            2'b10:   res = a ^ b;
            default: res = ~(a | b);
        endcase
    end
endmodule

// File: rtl/combo_alu_shift.sv
// Module: bidirectional barrel shifter built from one right-shifting ladder.
// Left shifts reverse the operand before and after the ladder.
// Assumes WIDTH is a power of two; the amount uses log2(WIDTH) bits.
module combo_alu_shift #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] value,
    input  logic [SHW-1:0]   amount,
    input  logic             go_right,
    input  logic             arith,
    output logic [WIDTH-1:0] res
);
    logic [WIDTH-1:0] flipped_in;
    logic [WIDTH-1:0] ladder_out_rev;
    logic [WIDTH-1:0] ladder_src;
    logic             fill;
    logic [WIDTH-1:0] stage [SHW+1];

    // Bit-reverse the input and the ladder output for left shifts.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign flipped_in[i]     = value[WIDTH-1-i];
        assign ladder_out_rev[i] = stage[SHW][WIDTH-1-i];
    end

    // Select ladder source and the bit shifted in from the top.
    always_comb begin
        ladder_src = go_right ? value : flipped_in;
        fill       = go_right & arith & value[WIDTH-1];
    end

    assign stage[0] = ladder_src;

    // One ladder rung per amount bit, each shifting by a power of two.
    for (genvar s = 0; s < SHW; s++) begin : g_rung
        localparam int DIST = 1 << s;
        assign stage[s+1] = amount[s]
            ? {{DIST{fill}}, stage[s][WIDTH-1:DIST]}
            : stage[s];
    end

    // Undo the reversal when shifting left.
    always_comb begin
        res = go_right ? stage[SHW] : ladder_out_rev;
    end
endmodule

// File: rtl/combo_alu.sv
// Module: combined ALU top; decodes the 5-bit code, runs the arithmetic,
// boolean and shift units in parallel and selects one result plus a zero flag.
// Purely combinational; no clock or reset is used.
module combo_alu #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [4:0]       fn,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    import combo_alu_pkg::*;

    fn_t              code;
    path_e            path;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] bool_res;
    logic [WIDTH-1:0] shift_res;

    // Unpack the operation code and decide the output path.
    always_comb begin
        code = fn_t'(fn);
        path = pick_path(code);
    end

    combo_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .a            (a),
        .b            (b),
        .sub_req      (code.sub),
        .cmp_en       (code.sel[0]),
        .cmp_unsigned (code.sel[1]),
        .res          (arith_res)
    );

    combo_alu_bool #(.WIDTH(WIDTH)) u_bool (
        .a   (a),
        .b   (b),
        .sel (code.sel),
        .res (bool_res)
    );

    combo_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .value    (b),
        .amount   (a[SHW-1:0]),
        .go_right (code.sel[1]),
        .arith    (code.sel[0]),
        .res      (shift_res)
    );

    // Final result selection.
    always_comb begin
        case (path)
            PATH_MATH:  result = arith_res;
            PATH_SHIFT: result = shift_res;
            default:    result = bool_res;
        endcase
    end

    // Zero flag over the selected result.
    assign zero = (result == '0);
endmodule

// File: rtl/combo_alu_chk.sv
// Module: property checker for combo_alu, attached by bind.
// Checks only once all inputs are known.
module combo_alu_chk #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [4:0]       fn,
    input logic [WIDTH-1:0] result,
    input logic             zero
);
    // Relate outputs to operands for each operation class.
    always_comb begin
        if (!$isunknown({a, b, fn, result, zero})) begin
            assert_zero_flag_R9: assert (zero == (result == '0))
                else $error("zero flag mismatch");
            if (fn[0] && !fn[2] && !fn[4]) begin
                assert_add_R2: assert (result == WIDTH'(a + b))
                    else $error("add mismatch");
            end
            if (fn[0] && !fn[2] && fn[4]) begin
                assert_sub_R3: assert (result == WIDTH'(a - b))
                    else $error("sub mismatch");
            end
            if (fn[0] && fn[3:2] == 2'b01) begin
                assert_slt_signed_R4: assert (result == WIDTH'($signed(a) < $signed(b)))
                    else $error("signed compare mismatch");
            end
            if (fn[0] && fn[3:2] == 2'b11) begin
                assert_slt_unsigned_R5: assert (result == WIDTH'(a < b))
                    else $error("unsigned compare mismatch");
            end
            if (!fn[0] && fn[1] && !fn[3]) begin
                assert_shl_R6: assert (result == (b << a[SHW-1:0]))
                    else $error("left shift mismatch");
            end
            if (!fn[0] && !fn[1] && fn[3:2] == 2'b00) begin
                assert_and_R8: assert (result == (a & b))
                    else $error("and mismatch");
            end
        end
    end
endmodule

bind combo_alu combo_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a      (a),
    .b      (b),
    .fn     (fn),
    .result (result),
    .zero   (zero)
);

// File: tb/combo_alu_bench.sv
`timescale 1ns/100ps
module combo_alu_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [7:0]  a8, b8, r8;
    logic [31:0] a32, b32, r32;
    logic [4:0]  fn8, fn32;
    logic        z8, z32;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    combo_alu #(.WIDTH(8)) u_combo_alu (
        .a(a8), .b(b8), .fn(fn8), .result(r8), .zero(z8)
    );
    combo_alu #(.WIDTH(32)) u_combo_alu_w32 (
        .a(a32), .b(b32), .fn(fn32), .result(r32), .zero(z32)
    );

    // Arithmetic model of the requirements for width w (power of two, <= 32).
    function automatic longint unsigned model(int w, longint unsigned ai,
                                              longint unsigned bi, logic [4:0] f);
        longint unsigned mask = (64'd1 << w) - 1;
        longint unsigned x = ai & mask;
        longint unsigned y = bi & mask;
        longint sx = x[w-1] ? longint'(x) - (longint'(1) << w) : longint'(x);
        longint sy = y[w-1] ? longint'(y) - (longint'(1) << w) : longint'(y);
        int sh = int'(x & longint'(w - 1));
        longint unsigned r;
        if (f[0]) begin
            if (!f[2])     r = f[4] ? x - y : x + y;
            else if (f[3]) r = (x < y) ? 1 : 0;
            else           r = (sx < sy) ? 1 : 0;
        end else if (f[1]) begin
            if (!f[3])     r = y << sh;
            else if (!f[2]) r = y >> sh;
            else           r = longint'(sy >>> sh);
        end else begin
            case (f[3:2])
                2'b00:   r = x & y;
                2'b01:   r = x | y;
                2'b10:   r = x ^ y;
                default: r = ~(x | y);
            endcase
        end
        return r & mask;
    endfunction

    function automatic string tag_of(logic [4:0] f);
        if (f[0] && f[1])         return "R1";
        if (f[0] && !f[2])        return f[4] ? "R3" : "R2";
        if (f[0] && !f[3])        return "R4";
        if (f[0])                 return "R5";
        if (f[4])                 return "R10";
        if (f[1] && !f[3])        return "R6";
        if (f[1])                 return "R7";
        return "R8";
    endfunction

    task automatic check(string req, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s a8=%h b8=%h fn8=%b a32=%h b32=%h fn32=%b actual=%h expected=%h",
                     req, a8, b8, fn8, a32, b32, fn32, act, exp);
        end
    endtask

    task automatic run32(logic [31:0] x, logic [31:0] y, logic [4:0] f, string req);
        longint unsigned e;
        a32 = x; b32 = y; fn32 = f;
        #0.3;
        e = model(32, x, y, f);
        check(req, r32, e);
        check("R9", z32, (e == 0) ? 1 : 0);
    endtask

    initial begin
        a8 = '0; b8 = '0; fn8 = '0;
        a32 = '0; b32 = '0; fn32 = '0;
        #1;
        // Quiet inputs: AND of zeros gives zero result, zero flag high (R8, R9).
        check("R8", r8, 0);
        check("R9", z8, 1);

        // Near-exhaustive 8-bit sweep: all codes, all A, 32 spread B values.
        for (int f = 0; f < 32; f++) begin
            for (int x = 0; x < 256; x++) begin
                for (int j = 0; j < 32; j++) begin
                    longint unsigned e;
                    int y = (j * 8 + (j % 8)) & 255;
                    a8 = 8'(x); b8 = 8'(y); fn8 = 5'(f);
                    #0.25;
                    e = model(8, longint'(x), longint'(y), 5'(f));
                    check(tag_of(5'(f)), r8, e);
                    check("R9", z8, (e == 0) ? 1 : 0);
                    #0.25;
                end
            end
        end

        // 32-bit directed corner cases.
        run32(32'hFFFF_FFFF, 32'h0000_0001, 5'b0_00_0_1, "R2");  // wrap to zero
        run32(32'h7FFF_FFFF, 32'h0000_0001, 5'b0_00_0_1, "R2");
        run32(32'h0000_0000, 32'h0000_0001, 5'b1_00_0_1, "R3");
        run32(32'h1234_5678, 32'h1234_5678, 5'b1_00_0_1, "R3");
        run32(32'h8000_0000, 32'h7FFF_FFFF, 5'b0_01_0_1, "R4");  // min < max
        run32(32'h7FFF_FFFF, 32'h8000_0000, 5'b1_01_0_1, "R4");
        run32(32'hFFFF_FFFF, 32'h0000_0000, 5'b0_01_0_1, "R4");
        run32(32'h0000_0000, 32'hFFFF_FFFF, 5'b0_11_0_1, "R5");
        run32(32'h8000_0000, 32'h7FFF_FFFF, 5'b1_11_0_1, "R5");
        run32(32'h0000_0021, 32'h8000_0001, 5'b0_00_1_0, "R6");  // amount 33 -> 1
        run32(32'hFFFF_FFE0, 32'h0000_00FF, 5'b0_00_1_0, "R6");  // amount 0
        run32(32'h0000_001F, 32'h8000_0000, 5'b0_11_1_0, "R7");
        run32(32'h0000_001F, 32'h8000_0000, 5'b0_10_1_0, "R7");
        run32(32'h0000_0004, 32'hF000_000F, 5'b1_11_1_0, "R10");
        run32(32'h0F0F_0F0F, 32'h00FF_00FF, 5'b0_11_0_0, "R8");
        run32(32'h0F0F_0F0F, 32'h00FF_00FF, 5'b0_10_0_0, "R8");
        run32(32'h0000_0005, 32'h0000_0003, 5'b1_00_1_1, "R1");  // math beats shift
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule